// File: doc/BRIEF.md
# Opportunistic DRAM Refresh Scheduler

This block decides when a refresh cycle is issued to an asynchronous DRAM array that is shared with a fast 68000-style processor. A free-running counter splits time into fixed refresh periods, and exactly one refresh is owed in each period. The refresh length is set by the RAM sequencer, not by this block. The scheduler issues a start pulse to the sequencer and waits for the sequencer's completion pulse.

In the early, relaxed part of a period the scheduler stays out of the CPU's way. It launches the refresh only when the CPU begins a read from ROM or from the slow expansion bus. That cycle keeps the CPU busy anyway, so the refresh costs the CPU nothing. When the late, urgent part of the period begins with no refresh completed yet, the scheduler launches the refresh at once. It then blocks CPU DRAM accesses until the refresh completes.

When no refresh is running or urgently owed, a CPU DRAM request is granted in the same cycle, so it completes with zero wait states. At the default 25 MHz clock the period is 350 cycles (14 µs) and the urgent window opens at cycle 250, about 4 µs before the period ends. Both values are parameters.

Top module: `refresh_scheduler`

## Requirements
- R1: After reset release, `ref_urgent` is 0 for the first URGENT_AT rising edges. It is 1 from the edge that brings the period count to URGENT_AT up to the end of the period, and the period wraps to count 0 after PERIOD edges (defaults 350 and 250).
- R2: While a refresh is owed and the period is not urgent, a cycle with `cpu_start`=1, `cpu_read`=1 and (`sel_rom`=1 or `sel_slow`=1) makes `ref_start` go high at the next rising edge.
- R3: A CPU write (`cpu_read`=0), a read with neither `sel_rom` nor `sel_slow` set, or a target selection without `cpu_start` starts no refresh.
- R4: At most one refresh starts per period. The completed flag clears at the period wrap, so a qualifying slow read in the next period starts a new refresh.
- R5: If no refresh has completed or is running when the count reaches URGENT_AT, `ref_start` goes high at the following rising edge, with no CPU activity needed.
- R6: `ram_go` is 0 while a refresh is running, from the `ref_start` cycle through the cycle in which `ref_done` is sampled. It is also 0 while the urgent window is open and the period's refresh is still owed.
- R7: When no refresh is running or urgently owed, `ram_go` follows `ram_req` in the same cycle (zero wait states). This includes the urgent window once the period's refresh has completed.
- R8: `ref_start` is high for exactly one cycle per refresh. A started refresh is never abandoned: the scheduler stays busy until `ref_done` arrives.
- R9: If a period wraps without its refresh having completed, `ref_miss` goes to 1 and stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_start | input | 1 | One-cycle strobe marking the start of any CPU bus cycle |
| cpu_read | input | 1 | The starting cycle is a read |
| sel_rom | input | 1 | The starting cycle targets ROM |
| sel_slow | input | 1 | The starting cycle targets the slow expansion bus |
| ram_req | input | 1 | CPU wants the DRAM (level, held until granted) |
| ref_done | input | 1 | Sequencer pulse: the refresh cycle has finished |
| ref_start | output | 1 | One-cycle pulse telling the sequencer to run a refresh |
| ram_go | output | 1 | CPU DRAM access may proceed this cycle |
| ref_urgent | output | 1 | The urgent window of the current period is open |
| ref_miss | output | 1 | Sticky flag: a period ended without a completed refresh |

## Verification
The bench checks that only a slow-target read launches an early refresh. A design that also accepted writes or DRAM reads would pulse `ref_start` in the write and DRAM-read scenario. It checks that a second slow read in the same period is ignored, but one just after the wrap is not. A done flag that never cleared would starve the next period, and one that cleared too early would issue two refreshes. For the urgent case it checks the exact edge at which the grant drops and the start pulse follows. An off-by-one threshold, or a grant that leaks through while the refresh is owed, shows up there. Finally, it withholds `ref_done` across a wrap to confirm that the miss flag rises on the wrap edge and stays set.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

    localparam int DEF_PERIOD_CYC = 350;
    localparam int DEF_URGENT_CYC = 250;

    typedef enum logic { RS_IDLE, RS_RUN } rs_state_t;

    typedef struct packed {
        logic start;
        logic read;
        logic rom;
        logic slow;
    } cpu_cyc_t;

    typedef struct packed {
        logic urgent;
        logic wrap;
    } period_t;

    function automatic logic hides_refresh(cpu_cyc_t c);
        return c.start && c.read && (c.rom || c.slow);
    endfunction

endpackage

// File: rtl/refsched_timer.sv
module refsched_timer
    import refsched_pkg::*;
#(
    parameter int PERIOD_CYC = DEF_PERIOD_CYC,
    parameter int URGENT_CYC = DEF_URGENT_CYC
) (
    input  logic    clk,
    input  logic    rst,
    output period_t per
);
    localparam int CW = $clog2(PERIOD_CYC);
    localparam logic [CW-1:0] LAST  = CW'(PERIOD_CYC - 1);
    localparam logic [CW-1:0] URG_Q = CW'(URGENT_CYC);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        per.wrap   = (cnt_q == LAST);
        per.urgent = (cnt_q >= URG_Q);
    end
endmodule

// File: rtl/refsched_ctrl.sv
module refsched_ctrl
    import refsched_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  period_t per,
    input  logic    hide_ok,
    input  logic    ref_done,
    output logic    ref_start,
    output logic    running,
    output logic    done_q,
    output logic    miss_q
);
    rs_state_t state_q;
    logic      late_q;
    logic      finish;
    logic      launch;

    assign finish  = (state_q == RS_RUN) && ref_done;
    assign launch  = (state_q == RS_IDLE) && !done_q && !per.wrap
                     && (per.urgent || hide_ok);
    assign running = (state_q == RS_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= RS_IDLE;
            ref_start <= 1'b0;
            done_q    <= 1'b0;
            late_q    <= 1'b0;
            miss_q    <= 1'b0;
        end else begin
            ref_start <= launch;
            case (state_q)
                RS_IDLE: if (launch) state_q <= RS_RUN;
                RS_RUN:  if (ref_done) state_q <= RS_IDLE;
                default: state_q <= RS_IDLE;
            endcase
            // a refresh straddling the wrap belongs to the old period
            if (per.wrap) begin
                late_q <= running && !ref_done;
            end else if (finish) begin
                late_q <= 1'b0;
            end
            if (per.wrap) begin
                done_q <= 1'b0;
            end else if (finish && !late_q) begin
                done_q <= 1'b1;
            end
            if (per.wrap && !done_q && !finish) begin
                miss_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/refsched_gate.sv
module refsched_gate
    import refsched_pkg::*;
(
    input  period_t  per,
    input  cpu_cyc_t cyc,
    input  logic     running,
    input  logic     done_q,
    input  logic     ram_req,
    output logic     hide_ok,
    output logic     ram_go
);
    logic hold;

    always_comb begin
        hide_ok = hides_refresh(cyc);
        hold    = running || (per.urgent && !done_q);
        ram_go  = ram_req && !hold;
    end
endmodule

// File: rtl/refresh_scheduler.sv
module refresh_scheduler
    import refsched_pkg::*;
#(
    parameter int PERIOD_CYC = DEF_PERIOD_CYC,
    parameter int URGENT_CYC = DEF_URGENT_CYC
) (
    input  logic clk,
    input  logic rst,
    input  logic cpu_start,
    input  logic cpu_read,
    input  logic sel_rom,
    input  logic sel_slow,
    input  logic ram_req,
    input  logic ref_done,
    output logic ref_start,
    output logic ram_go,
    output logic ref_urgent,
    output logic ref_miss
);
    period_t  per;
    cpu_cyc_t cyc;
    logic     hide_ok;
    logic     running;
    logic     done_q;

    assign cyc = '{start: cpu_start, read: cpu_read, rom: sel_rom, slow: sel_slow};

    refsched_timer #(.PERIOD_CYC(PERIOD_CYC), .URGENT_CYC(URGENT_CYC)) u_timer (
        .clk (clk),
        .rst (rst),
        .per (per)
    );

    refsched_gate u_gate (
        .per     (per),
        .cyc     (cyc),
        .running (running),
        .done_q  (done_q),
        .ram_req (ram_req),
        .hide_ok (hide_ok),
        .ram_go  (ram_go)
    );

    refsched_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .per       (per),
        .hide_ok   (hide_ok),
        .ref_done  (ref_done),
        .ref_start (ref_start),
        .running   (running),
        .done_q    (done_q),
        .miss_q    (ref_miss)
    );

    assign ref_urgent = per.urgent;
endmodule

// File: rtl/refresh_scheduler_chk.sv
module refresh_scheduler_chk (
    input logic clk,
    input logic rst,
    input logic cpu_start,
    input logic cpu_read,
    input logic sel_rom,
    input logic sel_slow,
    input logic ram_go,
    input logic ref_start,
    input logic ref_urgent,
    input logic ref_miss,
    input logic running,
    input logic done_q,
    input logic wrap
);
    logic [1:0] starts_q;

    always_ff @(posedge clk) begin
        if (rst || wrap) begin
            starts_q <= '0;
        end else if (ref_start && starts_q != 2'd3) begin
            starts_q <= starts_q + 1'b1;
        end
    end

    // R8
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ref_start |=> !ref_start);

    // R2
    early_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_start && !$past(ref_urgent)) |->
        $past(cpu_start && cpu_read && (sel_rom || sel_slow)));

    // R4
    one_per_period_chk: assert property (@(posedge clk) disable iff (rst)
        ref_start |-> (starts_q == 2'd0));

    // R6
    no_grant_on_start_chk: assert property (@(posedge clk) disable iff (rst)
        ref_start |-> !ram_go);

    // R5
    urgent_launch_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(ref_urgent) && !done_q && !running) |=> ref_start);

    // R9
    miss_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ref_miss |=> ref_miss);
endmodule

bind refresh_scheduler refresh_scheduler_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cpu_start  (cpu_start),
    .cpu_read   (cpu_read),
    .sel_rom    (sel_rom),
    .sel_slow   (sel_slow),
    .ram_go     (ram_go),
    .ref_start  (ref_start),
    .ref_urgent (ref_urgent),
    .ref_miss   (ref_miss),
    .running    (running),
    .done_q     (done_q),
    .wrap       (per.wrap)
);

// File: tb/test_refresh_scheduler.sv
`timescale 1ns/1ps
module test_refresh_scheduler;
    logic clk = 1'b0;
    logic rst;
    logic cpu_start, cpu_read, sel_rom, sel_slow, ram_req, ref_done;
    logic ref_start, ram_go, ref_urgent, ref_miss;
    int   n_cmp = 0;
    int   n_bad = 0;

    always #2 clk = ~clk;

    refresh_scheduler i_refresh_scheduler (
        .clk(clk), .rst(rst), .cpu_start(cpu_start), .cpu_read(cpu_read),
        .sel_rom(sel_rom), .sel_slow(sel_slow), .ram_req(ram_req),
        .ref_done(ref_done), .ref_start(ref_start), .ram_go(ram_go),
        .ref_urgent(ref_urgent), .ref_miss(ref_miss)
    );

    task automatic chk(string req, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        cpu_start = 0; cpu_read = 0; sel_rom = 0; sel_slow = 0;
        ram_req = 0; ref_done = 0;
    endtask

    task automatic apply_reset();
        idle_inputs();
        rst = 1;
        repeat (3) @(posedge clk);
        #1 rst = 0;   // edges counted from here: after n edges the count is n
    endtask

    task automatic t_reset();
        apply_reset();
        chk("R1 reset urgent", ref_urgent, 1'b0);
        chk("R8 reset start", ref_start, 1'b0);
        chk("R9 reset miss", ref_miss, 1'b0);
        ram_req = 1; #1;
        chk("R7 reset grant", ram_go, 1'b1);
        idle_inputs();
    endtask

    task automatic t_hidden();
        apply_reset();
        step(10);
        cpu_start = 1; cpu_read = 1; sel_rom = 1; ram_req = 1; #1;
        chk("R7 grant before refresh", ram_go, 1'b1);
        step(1);                                  // count 11
        chk("R2 start after ROM read", ref_start, 1'b1);
        chk("R6 hold at start", ram_go, 1'b0);
        cpu_start = 0; sel_rom = 0;
        step(1);                                  // 12
        chk("R8 start pulse ends", ref_start, 1'b0);
        chk("R6 hold while running", ram_go, 1'b0);
        ref_done = 1;
        step(1);                                  // 13
        ref_done = 0; #1;
        chk("R6 grant after done", ram_go, 1'b1);
        cpu_start = 1; sel_slow = 1;
        step(1);                                  // 14
        chk("R4 second slow read ignored", ref_start, 1'b0);
        cpu_start = 0; sel_slow = 0;
        step(246);                                // 260
        chk("R1 urgent open", ref_urgent, 1'b1);
        chk("R7 grant in urgent after done", ram_go, 1'b1);
        chk("R4 no urgent start after done", ref_start, 1'b0);
        step(90);                                 // wrapped to 0
        chk("R1 urgent cleared on wrap", ref_urgent, 1'b0);
        chk("R9 no miss when done", ref_miss, 1'b0);
        cpu_start = 1; sel_slow = 1;
        step(1);
        chk("R4 new period slow read starts", ref_start, 1'b1);
        idle_inputs();
    endtask

    task automatic t_no_trigger();
        apply_reset();
        step(5);
        cpu_start = 1; cpu_read = 0; sel_rom = 1;
        step(1);
        chk("R3 ROM write no start", ref_start, 1'b0);
        cpu_read = 1; sel_rom = 0;
        step(1);
        chk("R3 DRAM read no start", ref_start, 1'b0);
        cpu_start = 0; sel_slow = 1;
        step(1);
        chk("R3 no strobe no start", ref_start, 1'b0);
        idle_inputs();
        ram_req = 1; #1;
        chk("R3 grant unaffected", ram_go, 1'b1);
        idle_inputs();
    endtask

    task automatic t_urgent();
        apply_reset();
        ram_req = 1;
        step(249);
        chk("R1 not urgent at 249", ref_urgent, 1'b0);
        chk("R7 grant at 249", ram_go, 1'b1);
        step(1);
        chk("R1 urgent at 250", ref_urgent, 1'b1);
        chk("R6 hold when urgent owed", ram_go, 1'b0);
        chk("R5 start not yet", ref_start, 1'b0);
        step(1);
        chk("R5 urgent start", ref_start, 1'b1);
        chk("R6 hold running", ram_go, 1'b0);
        step(3);
        chk("R8 stays busy without done", ram_go, 1'b0);
        ref_done = 1;
        step(1);                                  // 255
        ref_done = 0; #1;
        chk("R6 grant after urgent done", ram_go, 1'b1);
        chk("R8 no restart", ref_start, 1'b0);
        step(95);                                 // 350 -> wrapped
        chk("R9 no miss", ref_miss, 1'b0);
        idle_inputs();
    endtask

    task automatic t_miss();
        apply_reset();
        step(349);
        chk("R9 miss low before wrap", ref_miss, 1'b0);
        step(1);
        chk("R9 miss on wrap", ref_miss, 1'b1);
        step(5);
        chk("R9 miss sticky", ref_miss, 1'b1);
        idle_inputs();
    endtask

    initial begin
        rst = 1;
        idle_inputs();
        t_reset();
        t_hidden();
        t_no_trigger();
        t_urgent();
        t_miss();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule